// File: doc/BRIEF.md
# Integer ALU with Stored Flags and Condition Test

This block is the execute-stage arithmetic unit of a small 32-bit processor. An operation enters through a valid/ready handshake. It carries a 2-operand request and a 4-bit function code, and it selects one of four operations: add, subtract, AND or XOR. The result leaves through a one-deep registered output stage that has its own valid/ready handshake. When the request is accepted with its `set_cc` bit high, the zero, sign and overflow flags are written into a flag register at the same clock edge.

A combinational evaluator reads the stored flags and a 4-bit condition code, and it returns one "condition holds" bit. Both conditional branches and conditional register moves use this same bit. Address arithmetic and stack-pointer steps go through the same adder with `set_cc` low, so they leave the flags untouched. A condition code applied after an accepted operation sees the flags that operation wrote.

Back-pressure works as follows. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output result holds steady and no new request is taken.

Top module: `alu_cc_unit`

## Requirements
- R1: Function code 0 returns `in_a + in_b` modulo 2^32.
- R2: Function code 1 returns `in_b - in_a` modulo 2^32.
- R3: Function code 2 returns the bitwise AND of the operands, and code 3 returns the bitwise XOR.
- R4: On an accepted request with `set_cc` high, ZF becomes 1 exactly when the result is zero and SF becomes the result's bit 31. OF becomes the signed overflow of the add or subtract, and it is cleared for AND, XOR and unlisted codes.
- R5: The flags keep their value in any cycle with no accepted request, or with an accepted request whose `set_cc` is low.
- R6: After reset, ZF=1, SF=0 and OF=0, `out_valid` is 0 and `in_ready` is 1.
- R7: Condition codes are 0 always, 1 le ((SF^OF)|ZF), 2 l (SF^OF), 3 e (ZF), 4 ne (!ZF), 5 ge (!(SF^OF)) and 6 g (!(SF^OF) & !ZF). Codes 7 to 15 give false.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` does not change. `in_ready` equals `!out_valid || out_ready`.
- R9: Function codes 4 to 15 return a zero result.
- R10: Results leave in the order their requests were accepted, one cycle after acceptance at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_fn | input | 4 | Operation select |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_set_cc | input | 1 | Write flags when the request is accepted |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Operation result |
| cond_fn | input | 4 | Condition code to evaluate |
| cond_true | output | 1 | Selected condition holds on stored flags |
| flag_z | output | 1 | Stored zero flag |
| flag_s | output | 1 | Stored sign flag |
| flag_o | output | 1 | Stored overflow flag |

## Verification
The properties assume that `in_valid`, the operands and `out_ready` are driven to known values once reset is released. They also assume that a consumer asserts `out_ready` only on its own schedule, with no combinational path from `in_ready`. The stimulus changes every input at the falling edge only. It holds a request steady until `in_ready` is seen high, and it then drops `in_valid` for at least a cycle. This way each flag check sees exactly one accepted operation. The consumer's ready follows a fixed stall pattern, independent of the design, and so the output stage is exercised both full and draining.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  localparam int FN_W = 4;

  typedef enum logic [FN_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_XOR = 4'd3
  } op_e;

  typedef enum logic [FN_W-1:0] {
    C_ALWAYS = 4'd0,
    C_LE     = 4'd1,
    C_LT     = 4'd2,
    C_EQ     = 4'd3,
    C_NE     = 4'd4,
    C_GE     = 4'd5,
    C_GT     = 4'd6
  } cond_e;

  typedef struct packed {
    logic z;
    logic s;
    logic o;
  } flags_t;

  localparam flags_t FLAGS_RST = '{z: 1'b1, s: 1'b0, o: 1'b0};
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [FN_W-1:0] fn,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    res,
  output flags_t          nflags
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_minus_a;
  logic         ov;

  assign b_minus_a = b - a;

  always_comb begin
    res = '0;
    ov  = 1'b0;
    case (fn)
      OP_ADD: begin
        res = a + b;
        ov  = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
      end
      OP_SUB: begin
        res = b_minus_a;
        ov  = (a[MSB] != b[MSB]) && (res[MSB] != b[MSB]);
      end
      OP_AND: res = a & b;
      OP_XOR: res = a ^ b;
      default: res = '0;
    endcase
  end

  assign nflags.z = (res == '0);
  assign nflags.s = res[MSB];
  assign nflags.o = ov;
endmodule

// File: rtl/cc_reg.sv
module cc_reg
  import alu_cc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= FLAGS_RST;
    else if (wr) q <= d;
  end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import alu_cc_pkg::*;
(
  input  logic [FN_W-1:0] cfn,
  input  flags_t          f,
  output logic            hit
);
  logic lt;
  assign lt = f.s ^ f.o;

  always_comb begin
    case (cfn)
      C_ALWAYS: hit = 1'b1;
      C_LE:     hit = lt | f.z;
      C_LT:     hit = lt;
      C_EQ:     hit = f.z;
      C_NE:     hit = ~f.z;
      C_GE:     hit = ~lt;
      C_GT:     hit = ~lt & ~f.z;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         take,
  output logic         valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else begin
      if (load) begin
        valid <= 1'b1;
        q     <= d;
      end else if (take) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [FN_W-1:0] in_fn,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  input  logic            in_set_cc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_result,
  input  logic [FN_W-1:0] cond_fn,
  output logic            cond_true,
  output logic            flag_z,
  output logic            flag_s,
  output logic            flag_o
);
  logic         accept;
  logic [W-1:0] res;
  flags_t       nflags;
  flags_t       cur;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  alu_core #(.W(W)) u_core (
    .fn(in_fn), .a(in_a), .b(in_b), .res(res), .nflags(nflags)
  );

  cc_reg u_cc (
    .clk(clk), .rst_n(rst_n), .wr(accept && in_set_cc), .d(nflags), .q(cur)
  );

  cond_eval u_cond (.cfn(cond_fn), .f(cur), .hit(cond_true));

  out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(accept), .d(res),
    .take(out_ready), .valid(out_valid), .q(out_result)
  );

  assign flag_z = cur.z;
  assign flag_s = cur.s;
  assign flag_o = cur.o;
endmodule

// File: rtl/alu_cc_chk.sv
module alu_cc_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [3:0]   in_fn,
  input logic         in_set_cc,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic [3:0]   cond_fn,
  input logic         cond_true,
  input logic         flag_z,
  input logic         flag_s,
  input logic         flag_o
);
  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result));

  // R8
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && in_set_cc) |=>
      $stable(flag_z) && $stable(flag_s) && $stable(flag_o));

  // R4
  logic_no_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_set_cc && (in_fn == 4'd2 || in_fn == 4'd3)
      |=> !flag_o);

  // R4
  zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_set_cc |=> flag_z == (out_result == '0));

  // R7
  always_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_fn == 4'd0 |-> cond_true);

  // R7
  unused_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_fn > 4'd6 |-> !cond_true);

  // R10
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

bind alu_cc_unit alu_cc_chk #(.W(W)) u_alu_cc_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_fn(in_fn), .in_set_cc(in_set_cc), .out_valid(out_valid),
  .out_ready(out_ready), .out_result(out_result), .cond_fn(cond_fn),
  .cond_true(cond_true), .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o)
);

// File: tb/test_alu_cc_unit.sv
module test_alu_cc_unit;
  localparam int PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [3:0]   in_fn = '0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_set_cc = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_result;
  logic [3:0]   cond_fn = '0;
  logic         cond_true;
  logic         flag_z, flag_s, flag_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] expq[$];
  logic mz = 1'b1, ms = 1'b0, mo = 1'b0;
  int stall_mode = 0;
  int cyc = 0;
  logic         prev_hold = 1'b0;
  logic [W-1:0] prev_res = '0;
  logic         done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  alu_cc_unit #(.W(W)) i_alu_cc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fn(in_fn), .in_a(in_a), .in_b(in_b), .in_set_cc(in_set_cc),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .cond_fn(cond_fn), .cond_true(cond_true),
    .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_res(input logic [3:0] f,
                                           input logic [W-1:0] a, input logic [W-1:0] b);
    case (f)
      4'd0: return a + b;
      4'd1: return b - a;
      4'd2: return a & b;
      4'd3: return a ^ b;
      default: return '0;
    endcase
  endfunction

  function automatic logic ref_ov(input logic [3:0] f,
                                  input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [W:0] wide;
    if (f == 4'd0) wide = $signed({a[W-1], a}) + $signed({b[W-1], b});
    else if (f == 4'd1) wide = $signed({b[W-1], b}) - $signed({a[W-1], a});
    else return 1'b0;
    return wide[W] != wide[W-1];
  endfunction

  function automatic logic ref_cond(input int c, input logic z, input logic s,
                                    input logic o);
    case (c)
      0: return 1'b1;
      1: return (s != o) || z;
      2: return s != o;
      3: return z;
      4: return !z;
      5: return s == o;
      6: return (s == o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  // consumer ready: fixed stall patterns
  always @(negedge clk) begin
    cyc <= cyc + 1;
    case (stall_mode)
      0: out_ready <= 1'b1;
      1: out_ready <= (cyc % 3) == 0;
      default: out_ready <= (cyc % 5) > 1;
    endcase
  end

  // monitor: pops expected results on each handshake
  always @(negedge clk) begin
    #(PERIOD/4);
    if (rst_n) begin
      if (prev_hold)  // R8 held output
        chk(out_valid && out_result == prev_res, "R8", out_result, prev_res);
      prev_hold = out_valid && !out_ready;
      prev_res  = out_result;
      chk(in_ready == (!out_valid || out_ready), "R8", {31'b0, in_ready},
          {31'b0, !out_valid || out_ready});
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R10", out_result, '0);
        end else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          chk(out_result == e, "R10 R1 R2 R3 R9", out_result, e);
        end
      end
    end
  end

  task automatic check_flags(input string req);
    chk({flag_z, flag_s, flag_o} == {mz, ms, mo}, req,
        {29'b0, flag_z, flag_s, flag_o}, {29'b0, mz, ms, mo});
    for (int c = 0; c < 16; c++) begin
      cond_fn = c[3:0];
      #1;
      chk(cond_true == ref_cond(c, mz, ms, mo), "R7", {31'b0, cond_true},
          {31'b0, ref_cond(c, mz, ms, mo)});
    end
  endtask

  // driver: one request, held until accepted
  task automatic do_op(input logic [3:0] f, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic cc, input string req);
    bit taken;
    taken = 0;
    while (!taken) begin
      @(negedge clk);
      in_valid = 1'b1; in_fn = f; in_a = a; in_b = b; in_set_cc = cc;
      #(PERIOD/4 + 1);
      if (in_ready) taken = 1;
    end
    expq.push_back(ref_res(f, a, b));
    if (cc) begin
      logic [W-1:0] r;
      r  = ref_res(f, a, b);
      mz = (r == '0); ms = r[W-1]; mo = ref_ov(f, a, b);
    end
    @(negedge clk);
    in_valid = 1'b0;
    #(PERIOD/4 + 2);
    check_flags(req);
  endtask

  initial begin
    #(PERIOD * 100000);
    chk(1'b0, "watchdog", '0, '1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #(PERIOD/4);
    // R6 reset state
    chk({flag_z, flag_s, flag_o} == 3'b100, "R6", {29'b0, flag_z, flag_s, flag_o}, 3'b100);
    chk(!out_valid && in_ready, "R6", {30'b0, out_valid, in_ready}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 add, R4 signed overflow
    do_op(4'd0, 32'd5, 32'd7, 1'b1, "R1 R4");
    do_op(4'd0, 32'h7fffffff, 32'd1, 1'b1, "R1 R4 ovf");
    do_op(4'd0, 32'hffffffff, 32'd1, 1'b1, "R1 R4 zero");
    do_op(4'd0, 32'h80000000, 32'h80000000, 1'b1, "R1 R4 neg ovf");
    // R2 sub is b - a
    do_op(4'd1, 32'd3, 32'd10, 1'b1, "R2");
    do_op(4'd1, 32'd10, 32'd3, 1'b1, "R2 R4 neg");
    do_op(4'd1, 32'd1, 32'h80000000, 1'b1, "R2 R4 ovf");
    do_op(4'd1, 32'h1234, 32'h1234, 1'b1, "R2 R4 eq");
    // R3 logic ops clear OF
    do_op(4'd0, 32'h7fffffff, 32'd1, 1'b1, "R4 set ovf");
    do_op(4'd2, 32'hf0f0f0f0, 32'h8ff00f0f, 1'b1, "R3 R4 and");
    do_op(4'd3, 32'hdeadbeef, 32'hdeadbeef, 1'b1, "R3 R4 xor");
    // R5 no flag write when set_cc low (address / stack step)
    do_op(4'd1, 32'd4, 32'h00001000, 1'b0, "R5");
    do_op(4'd0, 32'h80000000, 32'h80000000, 1'b0, "R5");
    // R9 unlisted op codes
    do_op(4'd4, 32'd9, 32'd9, 1'b1, "R9 R4");
    do_op(4'd15, 32'hffffffff, 32'h1, 1'b0, "R9");

    // R8 R10 back-pressure patterns
    for (int m = 1; m < 3; m++) begin
      stall_mode = m;
      for (int k = 0; k < 12; k++)
        do_op(k[3:0] % 4, 32'h01000000 * k - 32'd7, 32'h13579bdf ^ k, k[0], "R8 R10");
    end
    stall_mode = 0;
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, "R10", expq.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule